// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block is a synchronous sequencer that sits between a host issuing single-word read and write requests and an extended-data-out DRAM with 16-bit words. It splits each word address into a row part and a column part and sends both over one narrow, shared address bus. It generates the active-low row strobe, column strobe, write-enable and output-enable lines. The minimum strobe widths, the precharge interval, the row-to-column delay and the column access time are all set as clock-count parameters.

A row stays open after an access. A later request to the same row is a page hit and only pulses the column strobe. A request to a different row first closes the open row, waits out precharge, then opens the new row. An open row with no traffic for a set number of cycles is closed on its own. Read data is sampled after the column strobe has risen, which relies on the device keeping its data valid. Reads, writes and read-modify-write pairs can follow each other freely inside one open row.

The host holds a request until it sees a one-cycle acknowledge. Read data arrives with that acknowledge.

Top module: `edo_page_ctrl`

## Requirements
- R1: The request address is split with bits [17:9] as the row and bits [8:0] as the column. The row is on `dram_addr` when `dram_ras_n` falls, and the column is on `dram_addr` when `dram_cas_n` falls.
- R2: `dram_ras_n` only falls while `dram_cas_n` is high. `dram_cas_n` is only low while `dram_ras_n` is low. The address stays stable while `dram_cas_n` is low.
- R3: A read keeps `dram_we_n` high and `dram_oe_n` low while the column strobe is low. The controller samples `dram_dq_in` after `dram_cas_n` has risen, and `rd_valid` and `rd_data` appear with the acknowledge. The acknowledge becomes visible max(T_CAC, T_CAS)+1 cycles after the cycle in which `dram_cas_n` fell.
- R4: A write sets `dram_we_n` low and `dram_oe_n` high, and drives `dram_dq_oe` with the request data one cycle before `dram_cas_n` falls. It keeps driving through the cycle after `dram_cas_n` rises and stops driving in the next cycle. Its acknowledge appears T_CAS+1 cycles after the column strobe falls, and `rd_valid` stays low.
- R5: `dram_ras_n` stays low for at least T_RAS cycles before it rises. Each column strobe pulse lasts exactly T_CAS cycles.
- R6: `dram_ras_n` has been high for at least T_RP cycles before every fall, including the first fall after reset.
- R7: A request whose row equals the open row causes no row strobe activity. When it is presented during the acknowledge cycle of the previous access, `dram_cas_n` falls 3 cycles after it was presented.
- R8: A request to a row other than the open one raises `dram_ras_n` once and lowers it once, with the new row.
- R9: When a row is opened, `dram_cas_n` falls T_RCD+1 cycles after `dram_ras_n` falls.
- R10: With no accepted request, an open row closes (`dram_ras_n` rises) exactly IDLE_CLOSE cycles after the acknowledge cycle of the last access.
- R11: `req_ack` is a single-cycle pulse, one per request. A request present during an acknowledge cycle is not accepted in that cycle.
- R12: Under reset, all strobes and enables are high (inactive), `dram_dq_oe` is low, and `req_ack` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address: row in [17:9], column in [8:0] |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle acknowledge of the current request |
| rd_valid | output | 1 | Read data valid, coincident with acknowledge |
| rd_data | output | 16 | Captured read word |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven toward the device |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data returned by the device |

## Verification
On every cycle the assertions check the strobe ordering and nesting, the row-strobe width and precharge run lengths, the exact column pulse width, address stability under the column strobe, the absence of bus contention, and the shape of the acknowledge. Only the bench scenarios can show the end-to-end effects. These include correct row and column values for each address, data that survives a write and read back through a device model, capture latency under extended-data-out timing, and the choice between a hit and a miss. They also cover the exact moment the idle timeout closes a row.

// File: rtl/edo_pkg.sv
package edo_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLOSE,
      ST_PRE,
      ST_RCD,
      ST_COL,
      ST_CAS,
      ST_HOLD
   } edo_state_t;

   function automatic int emax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/edo_run_cnt.sv
// Saturating run-length counter: number of consecutive sampled cycles with level high.
module edo_run_cnt #(
   parameter int CW    = 4,
   parameter int LIMIT = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          level_i,
   output logic [CW-1:0] count_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     count_o <= '0;
      else if (!level_i)              count_o <= '0;
      else if (count_o < CW'(LIMIT))  count_o <= count_o + 1'b1;
   end
endmodule

// File: rtl/edo_row_track.sv
// Remembers which row is open and flags a page hit for the presented row.
module edo_row_track #(
   parameter int ROW_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_i,
   input  logic             close_i,
   input  logic [ROW_W-1:0] row_load_i,
   input  logic [ROW_W-1:0] row_cmp_i,
   output logic             is_open_o,
   output logic             hit_o
);
   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_open_o <= 1'b0;
         row_q     <= '0;
      end else if (close_i) begin
         is_open_o <= 1'b0;
      end else if (open_i) begin
         is_open_o <= 1'b1;
         row_q     <= row_load_i;
      end
   end

   assign hit_o = is_open_o && (row_q == row_cmp_i);
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
   import edo_pkg::*;
#(
   parameter int ROW_W      = 9,
   parameter int COL_W      = 9,
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = ROW_W + COL_W,
   parameter int T_RAS      = 4,
   parameter int T_CAS      = 2,
   parameter int T_RP       = 3,
   parameter int T_RCD      = 2,
   parameter int T_CAC      = 3,
   parameter int IDLE_CLOSE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ack,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ROW_W-1:0]  dram_addr,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic              dram_oe_n,
   output logic [DATA_W-1:0] dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [DATA_W-1:0] dram_dq_in
);
   localparam int PCW = $clog2(emax(emax(T_RCD, T_CAS), T_CAC) + 1) + 1;
   localparam int RCW = $clog2(emax(T_RP, T_RAS) + 1) + 1;
   localparam int ICW = $clog2(IDLE_CLOSE + 1) + 1;

   // elaboration-time parameter checks
   if (T_RAS < 1 || T_CAS < 1 || T_RP < 1 || T_RCD < 1 || T_CAC < 1 || IDLE_CLOSE < 1) begin : g_bad_timing
      $error("edo_page_ctrl: every timing count must be at least 1");
   end
   if (ADDR_W != ROW_W + COL_W) begin : g_bad_addr
      $error("edo_page_ctrl: ADDR_W must equal ROW_W + COL_W");
   end
   if (COL_W > ROW_W) begin : g_bad_col
      $error("edo_page_ctrl: column must fit on the row-wide address bus");
   end

   edo_state_t        state;
   logic [PCW-1:0]    cnt, acc;
   logic [ICW-1:0]    idle_cnt;
   logic              ras_n_q, cas_n_q, we_n_q, oe_n_q, dq_oe_q, ack_q, rdv_q;
   logic [ROW_W-1:0]  addr_q;
   logic [DATA_W-1:0] dq_q, rd_q;
   logic              lat_wr;
   logic [ROW_W-1:0]  lat_row;
   logic [COL_W-1:0]  lat_col;
   logic [DATA_W-1:0] lat_wd;

   // run lengths of the row strobe: index 0 = high (precharge), 1 = low (active)
   logic [RCW-1:0] run_cnt [2];
   for (genvar gi = 0; gi < 2; gi++) begin : g_run
      localparam int LIM = (gi == 0) ? T_RP : T_RAS;
      edo_run_cnt #(.CW(RCW), .LIMIT(LIM)) u_run (
         .clk     (clk),
         .rst_n   (rst_n),
         .level_i ((gi == 0) ? ras_n_q : ~ras_n_q),
         .count_o (run_cnt[gi])
      );
   end

   logic             hi_ok, lo_ok;
   logic [ROW_W-1:0] req_row;
   logic [COL_W-1:0] req_col;
   logic             trk_open, trk_hit;
   logic             go, col_setup, row_open_ev, idle_close, row_close_ev;
   logic             sel_wr;
   logic [COL_W-1:0] sel_col;
   logic [DATA_W-1:0] sel_wd;

   assign hi_ok   = run_cnt[0] >= RCW'(T_RP - 1);
   assign lo_ok   = run_cnt[1] >= RCW'(T_RAS - 1);
   assign req_row = req_addr[ADDR_W-1 -: ROW_W];
   assign req_col = req_addr[COL_W-1:0];

   always_comb begin
      go           = (state == ST_IDLE) && req_valid && !ack_q;
      col_setup    = (go && trk_hit) || ((state == ST_RCD) && (cnt == '0));
      row_open_ev  = (state == ST_PRE) && hi_ok;
      idle_close   = (state == ST_IDLE) && !go && trk_open &&
                     (idle_cnt >= ICW'(IDLE_CLOSE - 1)) && lo_ok;
      row_close_ev = ((state == ST_CLOSE) && lo_ok) || idle_close;
      sel_wr       = (state == ST_IDLE) ? req_write : lat_wr;
      sel_col      = (state == ST_IDLE) ? req_col   : lat_col;
      sel_wd       = (state == ST_IDLE) ? req_wdata : lat_wd;
   end

   edo_row_track #(.ROW_W(ROW_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .open_i     (row_open_ev),
      .close_i    (row_close_ev),
      .row_load_i (lat_row),
      .row_cmp_i  (req_row),
      .is_open_o  (trk_open),
      .hit_o      (trk_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         acc      <= '0;
         idle_cnt <= '0;
         ras_n_q  <= 1'b1;
         cas_n_q  <= 1'b1;
         we_n_q   <= 1'b1;
         oe_n_q   <= 1'b1;
         dq_oe_q  <= 1'b0;
         dq_q     <= '0;
         addr_q   <= '0;
         ack_q    <= 1'b0;
         rdv_q    <= 1'b0;
         rd_q     <= '0;
         lat_wr   <= 1'b0;
         lat_row  <= '0;
         lat_col  <= '0;
         lat_wd   <= '0;
      end else begin
         ack_q <= 1'b0;
         rdv_q <= 1'b0;
         if ((acc != '0) && (state == ST_CAS || state == ST_HOLD))
            acc <= acc - 1'b1;

         if (col_setup) begin
            addr_q  <= ROW_W'(sel_col);
            we_n_q  <= ~sel_wr;
            oe_n_q  <= sel_wr;
            dq_oe_q <= sel_wr;
            dq_q    <= sel_wd;
            state   <= ST_COL;
         end

         unique case (state)
            ST_IDLE: begin
               if (go) begin
                  lat_wr  <= req_write;
                  lat_row <= req_row;
                  lat_col <= req_col;
                  lat_wd  <= req_wdata;
                  if (!trk_hit) state <= trk_open ? ST_CLOSE : ST_PRE;
               end else begin
                  if (idle_cnt < ICW'(IDLE_CLOSE)) idle_cnt <= idle_cnt + 1'b1;
                  if (idle_close) ras_n_q <= 1'b1;
               end
            end
            ST_CLOSE: begin
               if (lo_ok) begin
                  ras_n_q <= 1'b1;
                  state   <= ST_PRE;
               end
            end
            ST_PRE: begin
               if (hi_ok) begin
                  ras_n_q <= 1'b0;
                  addr_q  <= lat_row;
                  cnt     <= PCW'(T_RCD - 1);
                  state   <= ST_RCD;
               end
            end
            ST_RCD: begin
               if (cnt != '0) cnt <= cnt - 1'b1;
            end
            ST_COL: begin
               cas_n_q <= 1'b0;
               cnt     <= PCW'(T_CAS - 1);
               acc     <= PCW'(T_CAC);
               state   <= ST_CAS;
            end
            ST_CAS: begin
               if (cnt == '0) begin
                  cas_n_q <= 1'b1;
                  state   <= ST_HOLD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_HOLD: begin
               if (lat_wr || (acc == '0)) begin
                  if (!lat_wr) begin
                     rd_q  <= dram_dq_in;
                     rdv_q <= 1'b1;
                  end
                  ack_q    <= 1'b1;
                  dq_oe_q  <= 1'b0;
                  we_n_q   <= 1'b1;
                  oe_n_q   <= 1'b1;
                  idle_cnt <= '0;
                  state    <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ack     = ack_q;
   assign rd_valid    = rdv_q;
   assign rd_data     = rd_q;
   assign dram_addr   = addr_q;
   assign dram_ras_n  = ras_n_q;
   assign dram_cas_n  = cas_n_q;
   assign dram_we_n   = we_n_q;
   assign dram_oe_n   = oe_n_q;
   assign dram_dq_out = dq_q;
   assign dram_dq_oe  = dq_oe_q;
endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk #(
   parameter int ROW_W = 9,
   parameter int T_RAS = 4,
   parameter int T_CAS = 2,
   parameter int T_RP  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ack,
   input logic             rd_valid,
   input logic [ROW_W-1:0] dram_addr,
   input logic             dram_ras_n,
   input logic             dram_cas_n,
   input logic             dram_we_n,
   input logic             dram_oe_n,
   input logic             dram_dq_oe
);
   logic [15:0] hi_run, lo_run, cas_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run  <= '0;
         lo_run  <= '0;
         cas_run <= '0;
      end else begin
         hi_run  <= dram_ras_n  ? ((hi_run  == 16'hFFFF) ? hi_run  : hi_run  + 1'b1) : '0;
         lo_run  <= !dram_ras_n ? ((lo_run  == 16'hFFFF) ? lo_run  : lo_run  + 1'b1) : '0;
         cas_run <= !dram_cas_n ? ((cas_run == 16'hFFFF) ? cas_run : cas_run + 1'b1) : '0;
      end
   end

   a_r6_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> (hi_run >= 16'(T_RP)));

   a_r5_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_ras_n) |-> (lo_run >= 16'(T_RAS)));

   a_r5_cas_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_cas_n) |-> (cas_run == 16'(T_CAS)));

   a_r2_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n);

   a_r2_ras_fall_cas_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> dram_cas_n);

   a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));

   a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      dram_dq_oe |-> dram_oe_n);

   a_r4_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cas_n && !dram_we_n) |-> dram_dq_oe);

   a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);

   a_r3_data_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> req_ack);
endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(
   .ROW_W (ROW_W),
   .T_RAS (T_RAS),
   .T_CAS (T_CAS),
   .T_RP  (T_RP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ack    (req_ack),
   .rd_valid   (rd_valid),
   .dram_addr  (dram_addr),
   .dram_ras_n (dram_ras_n),
   .dram_cas_n (dram_cas_n),
   .dram_we_n  (dram_we_n),
   .dram_oe_n  (dram_oe_n),
   .dram_dq_oe (dram_dq_oe)
);

// File: tb/edo_page_ctrl_tb.sv
`timescale 1ns/1ps
module edo_page_ctrl_tb;
   localparam int TRAS = 4, TCAS = 2, TRP = 3, TRCD = 2, TCAC = 3, TIDLE = 8;
   localparam int LAT_RD = ((TCAC > TCAS) ? TCAC : TCAS) + 1;
   localparam int LAT_WR = TCAS + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [17:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ack, rd_valid;
   logic [15:0] rd_data;
   logic [8:0]  dram_addr;
   logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
   logic [15:0] dram_dq_out;
   logic [15:0] dram_dq_in = 16'hBAD0;

   always #2.5 clk = ~clk;

   edo_page_ctrl #(
      .T_RAS(TRAS), .T_CAS(TCAS), .T_RP(TRP), .T_RCD(TRCD), .T_CAC(TCAC), .IDLE_CLOSE(TIDLE)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
      .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
      .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
      .dram_dq_in(dram_dq_in)
   );

   int total = 0, bad = 0, cyc = 0;
   bit done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] dflt(input logic [17:0] a);
      return a[15:0] ^ 16'h5A5A;
   endfunction

   // expectations set by the host, read by the device model
   logic [8:0]  exp_row = '0, exp_col = '0;
   logic [15:0] exp_wd = '0;
   bit          exp_wr = 1'b0, exp_new = 1'b0;
   int          ras_falls = 0, ras_fall_cyc = 0, cas_fall_cyc = 0;

   // device model and pin monitor
   logic [15:0] mem [int];
   bit   prev_ras = 1'b1, prev_cas = 1'b1, prev_ack = 1'b0, rel_chk = 1'b0, rd_acc = 1'b0;
   int   hi_len = 0, lo_len = 0, cas_len = 0, since_cas = 0;
   logic [8:0] m_row = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_ack) chk(!req_ack, "R11 ack longer than one cycle", req_ack, 0);
         if (rel_chk) begin
            chk(!dram_dq_oe, "R4 bus release", dram_dq_oe, 0);
            rel_chk = 1'b0;
         end
         if (!dram_ras_n && prev_ras) begin
            chk(hi_len >= TRP, "R6 precharge", hi_len, TRP);
            chk(dram_addr == exp_row, "R1 row address", dram_addr, exp_row);
            chk(dram_cas_n, "R2 cas high at ras fall", dram_cas_n, 1);
            m_row = dram_addr;
            ras_fall_cyc = cyc;
            ras_falls++;
         end
         if (dram_ras_n && !prev_ras) chk(lo_len >= TRAS, "R5 ras width", lo_len, TRAS);
         if (!dram_cas_n && prev_cas) begin
            chk(!dram_ras_n, "R2 cas under ras", dram_ras_n, 0);
            chk(dram_addr == exp_col, "R1 column address", dram_addr, exp_col);
            if (exp_new) chk(cyc - ras_fall_cyc == TRCD + 1, "R9 ras to cas", cyc - ras_fall_cyc, TRCD + 1);
            cas_fall_cyc = cyc;
            since_cas = 0;
            rd_acc = dram_we_n;
            if (!dram_we_n) begin
               chk(dram_dq_oe && dram_oe_n, "R4 write bus setup", {dram_dq_oe, dram_oe_n}, 3);
               chk(dram_dq_out == exp_wd, "R4 write data", dram_dq_out, exp_wd);
               mem[int'({m_row, dram_addr})] = dram_dq_out;
            end else begin
               chk(!dram_oe_n, "R3 output enable low", dram_oe_n, 0);
            end
         end
         if (dram_cas_n && !prev_cas) begin
            chk(cas_len == TCAS, "R5 cas width", cas_len, TCAS);
            if (exp_wr) begin
               chk(dram_dq_oe, "R4 bus held after cas rise", dram_dq_oe, 1);
               rel_chk = 1'b1;
            end
         end
      end
      if (dram_ras_n) begin hi_len++; lo_len = 0; end else begin lo_len++; hi_len = 0; end
      cas_len = dram_cas_n ? 0 : cas_len + 1;
      since_cas++;
      if (rd_acc && since_cas >= TCAC && !dram_oe_n && dram_we_n) begin
         if (mem.exists(int'({m_row, exp_col}))) dram_dq_in = mem[int'({m_row, exp_col})];
         else dram_dq_in = dflt({m_row, exp_col});
      end else begin
         dram_dq_in = 16'hBAD0;
      end
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
      prev_ack = req_ack;
   end

   // host side
   logic [15:0] shadow [int];
   bit   b_open = 1'b0;
   logic [8:0] b_row = '0;
   int   last_ack = -100;

   task automatic do_acc(input bit wr, input logic [8:0] row, input logic [8:0] col, input logic [15:0] wd);
      int  start;
      bit  b2b;
      logic [15:0] expd;
      exp_row = row; exp_col = col; exp_wd = wd; exp_wr = wr;
      exp_new = !(b_open && row == b_row);
      ras_falls = 0;
      start = cyc;
      b2b = (cyc == last_ack) && !exp_new;
      req_valid = 1'b1; req_write = wr; req_addr = {row, col}; req_wdata = wd;
      do @(negedge clk); while (!req_ack);
      req_valid = 1'b0;
      if (b2b) chk(cas_fall_cyc - start == 3, "R7 R11 hit timing", cas_fall_cyc - start, 3);
      chk(ras_falls == (exp_new ? 1 : 0), exp_new ? "R8 row reopen" : "R7 no ras on hit", ras_falls, exp_new ? 1 : 0);
      if (wr) begin
         chk(cyc - cas_fall_cyc == LAT_WR, "R4 write ack latency", cyc - cas_fall_cyc, LAT_WR);
         chk(!rd_valid, "R4 no rd_valid on write", rd_valid, 0);
         shadow[int'({row, col})] = wd;
      end else begin
         expd = shadow.exists(int'({row, col})) ? shadow[int'({row, col})] : dflt({row, col});
         chk(cyc - cas_fall_cyc == LAT_RD, "R3 read capture latency", cyc - cas_fall_cyc, LAT_RD);
         chk(rd_valid, "R3 rd_valid with ack", rd_valid, 1);
         chk(rd_data == expd, "R3 read data", rd_data, expd);
      end
      b_open = 1'b1; b_row = row;
      last_ack = cyc;
   endtask

   task automatic idle_close_check();
      while (cyc < last_ack + TIDLE - 1) @(negedge clk);
      chk(!dram_ras_n, "R10 row still open before timeout", dram_ras_n, 0);
      @(negedge clk);
      chk(dram_ras_n, "R10 row closed at timeout", dram_ras_n, 1);
      b_open = 1'b0;
   endtask

   initial begin
      logic [8:0] rows [4];
      logic [8:0] cols [3];
      rows = '{9'd0, 9'd1, 9'd511, 9'd256};
      cols = '{9'd0, 9'd511, 9'd37};
      repeat (5) @(negedge clk);
      chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R12 strobes idle in reset",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
      chk(!dram_dq_oe && !req_ack && !rd_valid, "R12 outputs quiet in reset",
          {dram_dq_oe, req_ack, rd_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      foreach (rows[i]) begin
         foreach (cols[j]) do_acc(1'b1, rows[i], cols[j], {rows[i][6:0], cols[j]} ^ 16'h3C3C);
         foreach (cols[j]) do_acc(1'b0, rows[i], cols[j], 16'h0);
         do_acc(1'b0, rows[i], 9'd37, 16'h0);
         do_acc(1'b1, rows[i], 9'd37, ~({rows[i][6:0], 9'd37} ^ 16'h3C3C));
         do_acc(1'b0, rows[i], 9'd37, 16'h0);
      end
      do_acc(1'b0, 9'd511, 9'd100, 16'h0);
      do_acc(1'b0, 9'd1, 9'd0, 16'h0);
      idle_close_check();
      do_acc(1'b0, 9'd1, 9'd511, 16'h0);
      do_acc(1'b1, 9'd1, 9'd200, 16'hC0DE);
      idle_close_check();
      do_acc(1'b0, 9'd1, 9'd200, 16'h0);
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge clk) begin
      if (!done && cyc > 100000) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL R11 watchdog expired actual=%0d expected=%0d", cyc, 100000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule